// File: doc/BRIEF.md
# Zoned Memory Cycle Controller

This block sequences external memory bus cycles for three address zones. Zones 0 and 1 hold static memory (ROM or SRAM) and zone 2 holds DRAM. A requester offers one access at a time on a valid/ready port, naming the zone, the direction and the upper four address bits. The block then walks the bus states T1, T2, T3, any number of T3W wait states, T4, and any trailing idle states. It drives the static chip selects, the output enable, the write strobe, the DRAM row and column strobes, and the four non-multiplexed upper address lines.

Each zone has its own wait count and its own idle count, supplied on plain configuration inputs. Both counts are captured when the access is accepted, so a later change to them does not disturb a cycle that is already running. A programmable down-counter requests CAS-before-RAS DRAM refresh cycles. A pending refresh wins over any access that has not yet started. While a refresh is pending or running, a requester that is holding valid sees a hold-off indication.

Back-pressure on the request port works as follows. An access is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The requester keeps its fields steady while valid is high and ready is low. `req_ready` does not depend on `req_valid`. Only the configuration inputs are re-read between accesses.

Top module: `zmem_cycle_ctrl`

## Requirements
- R1: After reset every strobe output is high (inactive), `ma_hi` is 0, `hold_wait` is 0, and `req_ready` is 1 while the refresh period is 0.
- R2: An access is taken at a clock edge with `req_valid` and `req_ready` both high, and T1 occupies the next cycle. `req_ready` stays low from T1 until the access reaches its release point (R8). Zone, direction and address bits are held from T1 to the end of T4.
- R3: For zone code 0 or 1, `cs_n[zone]` is low from T1 through T4. For zone code 2, `ras_n` is low from T1 through T4 and both chip selects stay high. Zone code 3 is reserved and is never offered.
- R4: The number of T3W states between T3 and T4 equals the accepted zone's wait field, captured at acceptance. The select therefore stays low for 4+W cycles, and W=0 gives exactly T1–T4.
- R5: A read drives `oe_n` low from T2 through T4. A write drives `we_n` low in T3 and every T3W. The two are never low together.
- R6: In a zone-2 access, `cas_n` is low from T3 through T4. Wait states therefore follow the CAS assertion, and CAS never falls without RAS already being low.
- R7: During T1 of a zone-0 or zone-1 access, `ma_hi` carries the accepted address bits 15..12. In every other cycle it is 0.
- R8: With an idle field I captured at acceptance, `req_ready` rises in T4 when I=0, or otherwise in the I-th idle cycle after T4. A request held valid therefore starts its T1 exactly I cycles after T4.
- R9: With a nonzero refresh period P (P of at least 6), refresh cycles start every P cycles while no access runs. With P=0, no refresh cycle starts.
- R10: A refresh cycle lasts four cycles with strobes as follows: `cas_n` low alone; then both low; then `ras_n` low alone; then both high. Chip selects, `oe_n` and `we_n` stay high throughout.
- R11: A pending refresh is served at the next release point in place of any waiting access, and `req_ready` is low while refresh is pending. Refresh and access strobes never overlap.
- R12: `hold_wait` is high whenever `req_valid` is high and a refresh is pending or running. The held access takes its T1 two cycles after the refresh's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_zone | input | 2 | Zone code: 0,1 static, 2 DRAM |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr_hi | input | 4 | Address bits 15..12 |
| wait_cfg | input | 9 | Wait field per zone, 3 bits each, zone z at bits 3z+2..3z |
| idle_cfg | input | 6 | Idle field per zone, 2 bits each, zone z at bits 2z+1..2z |
| refresh_period | input | 8 | Cycles between refresh requests, 0 disables |
| hold_wait | output | 1 | Request held off by refresh |
| cs_n | output | 2 | Static zone chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| ma_hi | output | 4 | Non-multiplexed upper address lines |

## Verification
The assertions assume that the zone code offered with valid is never 3. They also assume that the refresh period is either 0 or long enough, at least 6 cycles, for a refresh to finish before the next one is requested. The stimulus only draws zones 0 to 2 and only uses periods of 0, 7, 9 and 25. Configuration fields are re-randomized right after each acceptance. This tests that captured counts are unaffected, and it stays within the rule that fields only matter at acceptance.

// File: rtl/zmem_pkg.sv
package zmem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T3W,
    ST_T4,
    ST_TIDL,
    ST_RF1,
    ST_RF2,
    ST_RF3,
    ST_RF4
  } bus_st_e;

  function automatic logic in_access(bus_st_e s);
    return s inside {ST_T1, ST_T2, ST_T3, ST_T3W, ST_T4};
  endfunction

  function automatic logic in_refresh(bus_st_e s);
    return s inside {ST_RF1, ST_RF2, ST_RF3, ST_RF4};
  endfunction

endpackage

// File: rtl/zmem_refresh_timer.sv
module zmem_refresh_timer #(
  parameter int REF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] period,
  input  logic             ack,
  output logic             pend
);

  logic [REF_W-1:0] cnt_q;
  logic             fire;

  assign fire = (period != '0) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (period == '0)      cnt_q <= '0;
      else if (cnt_q == '0)  cnt_q <= period - REF_W'(1);
      else                   cnt_q <= cnt_q - REF_W'(1);

      if (fire)      pend <= 1'b1;
      else if (ack)  pend <= 1'b0;
    end
  end

  // a disabled timer never raises a new request
  assert_no_fire_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !pend) |=> !pend);

endmodule

// File: rtl/zmem_zone_cfg.sv
module zmem_zone_cfg #(
  parameter int NZ     = 3,
  parameter int WAIT_W = 3,
  parameter int IDLE_W = 2,
  parameter int ZONE_W = 2
) (
  input  logic [NZ*WAIT_W-1:0] wait_cfg,
  input  logic [NZ*IDLE_W-1:0] idle_cfg,
  input  logic [ZONE_W-1:0]    zone,
  output logic [WAIT_W-1:0]    wait_sel,
  output logic [IDLE_W-1:0]    idle_sel
);

  logic [WAIT_W-1:0] w_arr [NZ];
  logic [IDLE_W-1:0] i_arr [NZ];

  for (genvar z = 0; z < NZ; z++) begin : g_unpack
    assign w_arr[z] = wait_cfg[z*WAIT_W +: WAIT_W];
    assign i_arr[z] = idle_cfg[z*IDLE_W +: IDLE_W];
  end

  always_comb begin
    wait_sel = '0;
    idle_sel = '0;
    for (int z = 0; z < NZ; z++) begin
      if (zone == ZONE_W'(z)) begin
        wait_sel = w_arr[z];
        idle_sel = i_arr[z];
      end
    end
  end

endmodule

// File: rtl/zmem_cycle_fsm.sv
module zmem_cycle_fsm
  import zmem_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int IDLE_W = 2,
  parameter int ZONE_W = 2,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ZONE_W-1:0] req_zone,
  input  logic              req_write,
  input  logic [HI_W-1:0]   req_addr_hi,
  input  logic [WAIT_W-1:0] wait_sel,
  input  logic [IDLE_W-1:0] idle_sel,
  input  logic              ref_pend,
  output logic              req_ready,
  output logic              hold_wait,
  output logic              ref_ack,
  output bus_st_e           st_q,
  output logic [ZONE_W-1:0] zone_q,
  output logic              wr_q,
  output logic [HI_W-1:0]   addr_hi_q
);

  localparam int CNT_W = (WAIT_W > IDLE_W) ? WAIT_W : IDLE_W;

  bus_st_e           st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WAIT_W-1:0] wait_q;
  logic [IDLE_W-1:0] idle_q;
  logic              ready_pt;
  logic              take;

  assign ready_pt = (st_q == ST_IDLE)
                 || (st_q == ST_T4   && idle_q == '0)
                 || (st_q == ST_TIDL && cnt_q == CNT_W'(1));
  assign req_ready = ready_pt && !ref_pend;
  assign ref_ack   = ready_pt && ref_pend;
  assign take      = req_valid && req_ready;
  assign hold_wait = req_valid && (ref_pend || in_refresh(st_q));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (ready_pt) begin
      if (ref_pend)       st_d = ST_RF1;
      else if (req_valid) st_d = ST_T1;
      else                st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_T1: st_d = ST_T2;
        ST_T2: begin
          st_d  = ST_T3;
          cnt_d = CNT_W'(wait_q);
        end
        ST_T3, ST_T3W: begin
          if (cnt_q == '0) begin
            st_d = ST_T4;
          end else begin
            st_d  = ST_T3W;
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        ST_T4: begin
          st_d  = ST_TIDL;
          cnt_d = CNT_W'(idle_q);
        end
        ST_TIDL: cnt_d = cnt_q - CNT_W'(1);
        ST_RF1:  st_d = ST_RF2;
        ST_RF2:  st_d = ST_RF3;
        ST_RF3:  st_d = ST_RF4;
        ST_RF4:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      zone_q    <= '0;
      wr_q      <= 1'b0;
      addr_hi_q <= '0;
      wait_q    <= '0;
      idle_q    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (take) begin
        zone_q    <= req_zone;
        wr_q      <= req_write;
        addr_hi_q <= req_addr_hi;
        wait_q    <= wait_sel;
        idle_q    <= idle_sel;
      end
    end
  end

  // captured fields do not move once the cycle is past T1
  assert_fields_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access(st_q) && st_q != ST_T1) |->
      ($stable(zone_q) && $stable(wr_q) && $stable(addr_hi_q)));

  // T3 goes straight to T4 only for a zero wait field
  assert_wait_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T4 && $past(st_q) == ST_T3) |-> (wait_q == '0));

  // a wait state is only entered from T3 or another wait state
  assert_wait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T3W) |-> ($past(st_q) inside {ST_T3, ST_T3W}));

  // pending refresh beats a waiting request at the idle point
  assert_refresh_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ref_pend) |=> (st_q == ST_RF1));

  // a held-off requester is never accepted
  assert_hold_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wait |-> !req_ready);

endmodule

// File: rtl/zmem_strobe_gen.sv
module zmem_strobe_gen
  import zmem_pkg::*;
#(
  parameter int N_STATIC = 2,
  parameter int ZONE_W   = 2,
  parameter int HI_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_st_e             st_q,
  input  logic [ZONE_W-1:0]   zone_q,
  input  logic                wr_q,
  input  logic [HI_W-1:0]     addr_hi_q,
  output logic [N_STATIC-1:0] cs_n,
  output logic                oe_n,
  output logic                we_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic [HI_W-1:0]     ma_hi
);

  localparam logic [ZONE_W-1:0] DRAM_Z = ZONE_W'(N_STATIC);

  logic acc, is_dram;

  assign acc     = in_access(st_q);
  assign is_dram = (zone_q == DRAM_Z);

  for (genvar z = 0; z < N_STATIC; z++) begin : g_cs
    assign cs_n[z] = !(acc && zone_q == ZONE_W'(z));
  end

  assign ras_n = !((acc && is_dram) || st_q inside {ST_RF2, ST_RF3});
  assign cas_n = !((is_dram && st_q inside {ST_T3, ST_T3W, ST_T4})
                   || st_q inside {ST_RF1, ST_RF2});
  assign oe_n  = !(!wr_q && st_q inside {ST_T2, ST_T3, ST_T3W, ST_T4});
  assign we_n  = !(wr_q && st_q inside {ST_T3, ST_T3W});
  assign ma_hi = (st_q == ST_T1 && !is_dram) ? addr_hi_q : '0;

  assert_oe_we_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  assert_dram_no_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (&cs_n));

  assert_cas_after_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

endmodule

// File: rtl/zmem_cycle_ctrl.sv
module zmem_cycle_ctrl
  import zmem_pkg::*;
#(
  parameter int N_STATIC = 2,
  parameter int WAIT_W   = 3,
  parameter int IDLE_W   = 2,
  parameter int REF_W    = 8,
  parameter int HI_W     = 4,
  localparam int NZ      = N_STATIC + 1,
  localparam int ZONE_W  = $clog2(NZ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ZONE_W-1:0]    req_zone,
  input  logic                 req_write,
  input  logic [HI_W-1:0]      req_addr_hi,
  input  logic [NZ*WAIT_W-1:0] wait_cfg,
  input  logic [NZ*IDLE_W-1:0] idle_cfg,
  input  logic [REF_W-1:0]     refresh_period,
  output logic                 hold_wait,
  output logic [N_STATIC-1:0]  cs_n,
  output logic                 oe_n,
  output logic                 we_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic [HI_W-1:0]      ma_hi
);

  logic [WAIT_W-1:0] wait_sel;
  logic [IDLE_W-1:0] idle_sel;
  logic              ref_pend, ref_ack;
  bus_st_e           st_q;
  logic [ZONE_W-1:0] zone_q;
  logic              wr_q;
  logic [HI_W-1:0]   addr_hi_q;

  zmem_zone_cfg #(
    .NZ(NZ), .WAIT_W(WAIT_W), .IDLE_W(IDLE_W), .ZONE_W(ZONE_W)
  ) cfg_i (
    .wait_cfg (wait_cfg),
    .idle_cfg (idle_cfg),
    .zone     (req_zone),
    .wait_sel (wait_sel),
    .idle_sel (idle_sel)
  );

  zmem_refresh_timer #(.REF_W(REF_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (refresh_period),
    .ack    (ref_ack),
    .pend   (ref_pend)
  );

  zmem_cycle_fsm #(
    .WAIT_W(WAIT_W), .IDLE_W(IDLE_W), .ZONE_W(ZONE_W), .HI_W(HI_W)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_zone    (req_zone),
    .req_write   (req_write),
    .req_addr_hi (req_addr_hi),
    .wait_sel    (wait_sel),
    .idle_sel    (idle_sel),
    .ref_pend    (ref_pend),
    .req_ready   (req_ready),
    .hold_wait   (hold_wait),
    .ref_ack     (ref_ack),
    .st_q        (st_q),
    .zone_q      (zone_q),
    .wr_q        (wr_q),
    .addr_hi_q   (addr_hi_q)
  );

  zmem_strobe_gen #(
    .N_STATIC(N_STATIC), .ZONE_W(ZONE_W), .HI_W(HI_W)
  ) strb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .zone_q    (zone_q),
    .wr_q      (wr_q),
    .addr_hi_q (addr_hi_q),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ma_hi     (ma_hi)
  );

  // refresh strobes and static selects never coincide
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (&cs_n));

endmodule

// File: tb/zmem_cycle_ctrl_tb_top.sv
module zmem_cycle_ctrl_tb_top;

  localparam int WAIT_W = 3;
  localparam int IDLE_W = 2;
  localparam int REF_W  = 8;
  localparam int NZ     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 req_valid = 1'b0;
  logic [1:0]           req_zone = '0;
  logic                 req_write = 1'b0;
  logic [3:0]           req_addr_hi = '0;
  logic [NZ*WAIT_W-1:0] wait_cfg = '0;
  logic [NZ*IDLE_W-1:0] idle_cfg = '0;
  logic [REF_W-1:0]     refresh_period = '0;
  logic                 req_ready, hold_wait, oe_n, we_n, ras_n, cas_n;
  logic [1:0]           cs_n;
  logic [3:0]           ma_hi;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic cas_log [0:79];
  logic ras_log [0:79];

  zmem_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_zone(req_zone), .req_write(req_write), .req_addr_hi(req_addr_hi),
    .wait_cfg(wait_cfg), .idle_cfg(idle_cfg), .refresh_period(refresh_period),
    .hold_wait(hold_wait), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .ras_n(ras_n), .cas_n(cas_n), .ma_hi(ma_hi)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic int wfield(int z);
    return int'(wait_cfg[z*WAIT_W +: WAIT_W]);
  endfunction

  function automatic int ifield(int z);
    return int'(idle_cfg[z*IDLE_W +: IDLE_W]);
  endfunction

  // one access, checked cycle by cycle from T1 (k=0) to the cycle after release
  task automatic access(int z, bit wr, logic [3:0] a, bit reshuffle);
    int w, i, n;
    int e_sel = 0, e_len = 0, e_oe = 0, e_we = 0, e_cas = 0, e_ma = 0, e_rdy = 0;
    req_zone = 2'(z); req_write = wr; req_addr_hi = a; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 50) begin tick(); n++; end
    w = wfield(z);
    i = ifield(z);
    tick();
    req_valid = 1'b0;
    if (reshuffle) begin
      wait_cfg = (NZ*WAIT_W)'($urandom);
      idle_cfg = (NZ*IDLE_W)'($urandom);
    end
    for (int k = 0; k <= 4 + w + i; k++) begin
      bit sel_lo;
      sel_lo = (z < 2) ? !cs_n[z[0]] : !ras_n;
      if (sel_lo != (k <= 3 + w)) e_sel++;
      if (sel_lo) e_len++;
      if (!oe_n != (!wr && k >= 1 && k <= 3 + w)) e_oe++;
      if (!we_n != (wr && k >= 2 && k <= 2 + w)) e_we++;
      if (!cas_n != (z == 2 && k >= 2 && k <= 3 + w)) e_cas++;
      if (ma_hi != ((k == 0 && z < 2) ? a : 4'd0)) e_ma++;
      if (req_ready != (k >= 3 + w + i)) e_rdy++;
      if (k < 4 + w + i) tick();
    end
    check(e_sel == 0, "R3 select window mismatches", e_sel, 0);
    check(e_len == 4 + w, "R4 select length", e_len, 4 + w);
    check(e_oe == 0 && e_we == 0, "R5 oe/we mismatches", e_oe + e_we, 0);
    check(e_cas == 0, "R6 cas window mismatches", e_cas, 0);
    check(e_ma == 0, "R7 upper address mismatches", e_ma, 0);
    check(e_rdy == 0, "R8 R2 ready timing mismatches", e_rdy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int starts, prev, e_shape, e_int, side, cnt, overlap, acc_cyc, holds, e_hold;
    void'($urandom(32'd4242));
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(cs_n == 2'b11 && oe_n && we_n && ras_n && cas_n, "R1 strobes idle",
          {cs_n, oe_n, we_n, ras_n, cas_n}, 63);
    check(ma_hi == 4'd0 && !hold_wait, "R1 ma_hi and hold", {ma_hi, hold_wait}, 0);

    // directed corners: zero counts, then maximum counts
    for (int z = 0; z < 3; z++) begin
      access(z, 1'b0, 4'hA, 1'b0);
      access(z, 1'b1, 4'h5, 1'b0);
    end
    wait_cfg = '1;
    idle_cfg = '1;
    for (int z = 0; z < 3; z++) begin
      access(z, 1'b0, 4'hC, 1'b0);
      access(z, 1'b1, 4'h3, 1'b0);
    end
    // random accesses, config rewritten mid-cycle
    for (int t = 0; t < 60; t++)
      access($urandom_range(0, 2), 1'($urandom), 4'($urandom), 1'b1);

    // R9 R10 refresh cadence and shape with no accesses
    refresh_period = 8'd9;
    side = 0;
    for (int k = 0; k < 80; k++) begin
      tick();
      cas_log[k] = cas_n;
      ras_log[k] = ras_n;
      if (cs_n != 2'b11 || !oe_n || !we_n) side++;
    end
    starts = 0; prev = -1; e_shape = 0; e_int = 0;
    for (int k = 1; k < 76; k++) begin
      if (!cas_log[k] && cas_log[k-1] && ras_log[k]) begin
        starts++;
        if (!(!cas_log[k+1] && !ras_log[k+1] && cas_log[k+2] && !ras_log[k+2]
              && cas_log[k+3] && ras_log[k+3])) e_shape++;
        if (prev >= 0 && k - prev != 9) e_int++;
        prev = k;
      end
    end
    check(starts >= 7, "R9 refresh count", starts, 8);
    check(e_int == 0, "R9 refresh interval errors", e_int, 0);
    check(e_shape == 0 && side == 0, "R10 refresh strobe shape", e_shape + side, 0);

    refresh_period = 8'd0;
    repeat (10) tick();
    cnt = 0;
    for (int k = 0; k < 40; k++) begin tick(); if (!cas_n) cnt++; end
    check(cnt == 0, "R9 no refresh with period 0", cnt, 0);

    // R12 hold-off during a running refresh
    wait_cfg = '0; idle_cfg = '0;
    refresh_period = 8'd25;
    cnt = 0;
    tick();
    while (!(!cas_n && ras_n) && cnt < 60) begin tick(); cnt++; end
    req_zone = 2'd0; req_write = 1'b0; req_addr_hi = 4'h9; req_valid = 1'b1;
    #1;
    e_hold = 0;
    for (int k = 0; k < 4; k++) begin
      if (!(hold_wait && !req_ready)) e_hold++;
      if (k < 3) tick();
    end
    check(e_hold == 0, "R12 hold during refresh", e_hold, 0);
    tick();
    check(req_ready && !hold_wait, "R12 release after refresh", {req_ready, hold_wait}, 2);
    tick();
    check(cs_n[0] == 1'b0, "R12 held access starts", cs_n[0], 0);
    req_valid = 1'b0;
    repeat (10) tick();

    // R11 refresh interleaved with a continuous request stream
    refresh_period = 8'd7;
    req_zone = 2'd1; req_write = 1'b0; req_valid = 1'b1;
    overlap = 0; starts = 0; acc_cyc = 0; holds = 0;
    tick();
    for (int k = 0; k < 60; k++) begin
      if (!cs_n[1] && (!cas_n || !ras_n)) overlap++;
      if (!cs_n[1]) acc_cyc++;
      if (hold_wait) holds++;
      if (!cas_n && ras_n && cas_log[0]) starts++;
      cas_log[0] = !(!cas_n && ras_n);
      tick();
    end
    req_valid = 1'b0;
    refresh_period = 8'd0;
    repeat (10) tick();
    check(overlap == 0, "R11 refresh/access overlap", overlap, 0);
    check(starts >= 7, "R11 refreshes served under load", starts, 8);
    check(acc_cyc > 0, "R11 accesses still served", acc_cyc, 1);
    check(holds > 0, "R12 hold seen under load", holds, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule